// File: doc/BRIEF.md
# Masked Lane Float Min/Max Reducer

The block takes one word from each of 32 lanes, treats each word as a single-precision float and returns the largest or smallest of them. Only lanes whose bit is set in a lane-enable mask count towards the result. Two mode flags change how inputs are treated. The magnitude flag clears each sign bit before the comparison. The NaN flag decides between two behaviours: a NaN in any lane poisons the result, or NaN lanes are left out of the comparison.

The values are compared as sign-magnitude numbers. Every negative value, including -0.0 and -infinity, orders below every positive value, so +0.0 is strictly greater than -0.0. Each tree node carries a flag that says whether it holds a real value. No identity constant is needed, and a node with no real value gives way to its neighbour. The result comes out of a registered binary tree with one level per cycle. A new set of operands can enter on every clock.

Top module: `lane_minmax_reducer`

## Requirements
- R1: With `pick_max` high, the result is the greatest participating non-NaN value.
- R2: With `pick_max` low, the result is the least participating non-NaN value.
- R3: Lane i occupies bits [32*i+31:32*i] of `lane_words` and takes part only when `lane_en[i]` is 1. A disabled lane has no effect on the result, even when it holds a NaN.
- R4: Ordering is sign-magnitude. +0.0 (0x00000000) is greater than -0.0 (0x80000000), and +inf (0x7F800000) and -inf (0xFF800000) are the extreme values.
- R5: With `use_abs` high, bit 31 of every lane is cleared before the comparison, so a non-NaN result has bit 31 equal to 0.
- R6: With `nan_poison` high, the result is 0x7FFFFFFF if any participating lane is a NaN. A NaN has all exponent bits [30:23] set and a nonzero mantissa [22:0].
- R7: With `nan_poison` low, NaN lanes are skipped. The result is 0x7FFFFFFF only when every participating lane is a NaN.
- R8: When no lane is enabled, the result is 0x7FFFFFFF.
- R9: `res_valid` is low during and after reset until a result arrives. It rises exactly 5 cycles after `op_valid` is sampled. One result leaves per cycle when operands arrive back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset of the valid pipeline |
| op_valid | input | 1 | Operands are present this cycle |
| lane_words | input | LANES*32 | Packed lane values, lane 0 in the low word |
| lane_en | input | LANES | Lane participation mask |
| pick_max | input | 1 | 1 selects maximum, 0 selects minimum |
| use_abs | input | 1 | Compare magnitudes only |
| nan_poison | input | 1 | Any NaN forces the canonical NaN |
| res_valid | output | 1 | Result is present this cycle |
| res_word | output | 32 | Reduced value |

## Verification
The bench builds the block with its default LANES of 32, which gives a full 5-level tree. At that size the worst-placed candidates are exercised: the highest lane, an extreme value at either end of the lane range, and a lane masked out right next to the winner. Each row of the stimulus table fills all 32 lanes with a pattern that alternates sign and grows in magnitude. Each row then overrides up to two lanes with zeros, infinities or NaNs. The rows are streamed back to back, so one reduction overlaps the next in the pipeline.

// File: rtl/lane_minmax_reducer.sv
module lane_minmax_reducer #(
  parameter int LANES = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_valid,
  input  logic [LANES*32-1:0] lane_words,
  input  logic [LANES-1:0]   lane_en,
  input  logic               pick_max,
  input  logic               use_abs,
  input  logic               nan_poison,
  output logic               res_valid,
  output logic [31:0]        res_word
);
  localparam int LEVELS = $clog2(LANES);
  localparam logic [31:0] CANON = 32'h7FFF_FFFF;

  function automatic logic is_nan(input logic [31:0] x);
    return (&x[30:23]) && (|x[22:0]);
  endfunction

  // sign-magnitude strict less-than
  function automatic logic below(input logic [31:0] a, input logic [31:0] b);
    if (a[31] != b[31]) return a[31];
    if (!a[31]) return a[30:0] < b[30:0];
    return a[30:0] > b[30:0];
  endfunction

  for (genvar l = 0; l <= LEVELS; l++) begin : lv
    localparam int N = LANES >> l;
    logic [31:0]  v [N];
    logic [N-1:0] h;
    logic [N-1:0] n;
    logic         vl, mx, np;

    if (l == 0) begin : leaf
      assign vl = op_valid;
      assign mx = pick_max;
      assign np = nan_poison;
      for (genvar i = 0; i < N; i++) begin : ln
        logic [31:0] x;
        assign x    = use_abs ? {1'b0, lane_words[i*32+:31]} : lane_words[i*32+:32];
        assign v[i] = x;
        assign h[i] = lane_en[i] & ~is_nan(x);
        assign n[i] = lane_en[i] &  is_nan(x);
      end
    end else begin : node
      logic [31:0]  nv [N];
      logic [N-1:0] nh, nn;
      for (genvar i = 0; i < N; i++) begin : pr
        logic [31:0] a, b;
        logic        ha, hb, take_b;
        assign a  = lv[l-1].v[2*i];
        assign b  = lv[l-1].v[2*i+1];
        assign ha = lv[l-1].h[2*i];
        assign hb = lv[l-1].h[2*i+1];
        assign take_b = hb & (~ha | (lv[l-1].mx ? below(a, b) : below(b, a)));
        assign nv[i] = take_b ? b : a;
        assign nh[i] = ha | hb;
        assign nn[i] = lv[l-1].n[2*i] | lv[l-1].n[2*i+1];
      end

      always_ff @(posedge clk) begin
        v  <= nv;
        h  <= nh;
        n  <= nn;
        mx <= lv[l-1].mx;
        np <= lv[l-1].np;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vl <= 1'b0;
        else        vl <= lv[l-1].vl;
      end
    end
  end

  assign res_valid = lv[LEVELS].vl;
  assign res_word  = (!lv[LEVELS].h[0] || (lv[LEVELS].np && lv[LEVELS].n[0]))
                     ? CANON : lv[LEVELS].v[0];
endmodule

module lane_minmax_reducer_chk #(
  parameter int LANES = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_valid,
  input logic [LANES*32-1:0] lane_words,
  input logic [LANES-1:0]   lane_en,
  input logic               pick_max,
  input logic               use_abs,
  input logic               nan_poison,
  input logic               res_valid,
  input logic [31:0]        res_word
);
  localparam int LEVELS = $clog2(LANES);
  localparam logic [31:0] CANON = 32'h7FFF_FFFF;

  logic [LANES-1:0] nan_lane;
  for (genvar i = 0; i < LANES; i++) begin : g_n
    assign nan_lane[i] = (&lane_words[i*32+23+:8]) && (|lane_words[i*32+:23]);
  end

  logic empty_in, poison_in, allnan_in;
  assign empty_in  = lane_en == '0;
  assign poison_in = nan_poison && |(lane_en & nan_lane);
  assign allnan_in = !empty_in && ((lane_en & ~nan_lane) == '0);

  logic [LEVELS-1:0] vp, ep, pp, ap, xp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vp <= '0; ep <= '0; pp <= '0; ap <= '0; xp <= '0;
    end else begin
      vp <= {vp[LEVELS-2:0], op_valid};
      ep <= {ep[LEVELS-2:0], op_valid & empty_in};
      pp <= {pp[LEVELS-2:0], op_valid & poison_in};
      ap <= {ap[LEVELS-2:0], op_valid & use_abs};
      xp <= {xp[LEVELS-2:0], op_valid & allnan_in};
    end
  end

  a_r9_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == vp[LEVELS-1]);
  a_r8_empty_canon: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ep[LEVELS-1]) |-> res_word == CANON);
  a_r6_poison_canon: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && pp[LEVELS-1]) |-> res_word == CANON);
  a_r7_all_nan_canon: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && xp[LEVELS-1]) |-> res_word == CANON);
  a_r5_abs_positive: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ap[LEVELS-1] && res_word != CANON) |-> !res_word[31]);
endmodule

bind lane_minmax_reducer lane_minmax_reducer_chk #(.LANES(LANES)) u_chk (.*);

// File: tb/lane_minmax_reducer_tb_top.sv
module lane_minmax_reducer_tb_top;
  localparam int LANES = 32;
  localparam int LAT   = 5;

  typedef struct packed {
    logic [31:0] mask;
    logic        mx, ab, nn;
    logic [5:0]  i0;
    logic [31:0] v0;
    logic [5:0]  i1;
    logic [31:0] v1;
    logic [31:0] exp;
    logic [3:0]  rq;
  } row_t;

  localparam int NV = 21;
  localparam row_t TBL [NV] = '{
    '{32'hFFFFFFFF,1'b1,1'b0,1'b0,6'd32,32'h0,6'd32,32'h0,32'h4000001E,4'd1},        // R1
    '{32'hFFFFFFFF,1'b0,1'b0,1'b0,6'd32,32'h0,6'd32,32'h0,32'hC000001F,4'd2},        // R2
    '{32'hFFFFFFFF,1'b1,1'b1,1'b0,6'd32,32'h0,6'd32,32'h0,32'h4000001F,4'd5},        // R5
    '{32'hFFFFFFFF,1'b0,1'b1,1'b0,6'd32,32'h0,6'd32,32'h0,32'h40000000,4'd5},        // R5
    '{32'h0000000A,1'b1,1'b0,1'b0,6'd32,32'h0,6'd32,32'h0,32'hC0000001,4'd3},        // R3
    '{32'h0000000A,1'b0,1'b0,1'b0,6'd32,32'h0,6'd32,32'h0,32'hC0000003,4'd3},        // R3
    '{32'hBFFFFFFF,1'b1,1'b0,1'b0,6'd32,32'h0,6'd32,32'h0,32'h4000001C,4'd3},        // R3
    '{32'h00000003,1'b1,1'b0,1'b0,6'd0,32'h0,6'd1,32'h80000000,32'h00000000,4'd4},   // R4
    '{32'h00000003,1'b0,1'b0,1'b0,6'd0,32'h0,6'd1,32'h80000000,32'h80000000,4'd4},   // R4
    '{32'h00000003,1'b0,1'b1,1'b0,6'd0,32'h0,6'd1,32'h80000000,32'h00000000,4'd5},   // R5
    '{32'hFFFFFFFF,1'b1,1'b0,1'b1,6'd5,32'h7FC00001,6'd32,32'h0,32'h7FFFFFFF,4'd6},  // R6
    '{32'hFFFFFFFF,1'b1,1'b0,1'b0,6'd5,32'h7FC00001,6'd32,32'h0,32'h4000001E,4'd7},  // R7
    '{32'hFFFFFFFF,1'b0,1'b0,1'b0,6'd4,32'hFFC00000,6'd32,32'h0,32'hC000001F,4'd7},  // R7
    '{32'hFFFFFFDF,1'b1,1'b0,1'b1,6'd5,32'h7FC00001,6'd32,32'h0,32'h4000001E,4'd3},  // R3
    '{32'h00000003,1'b1,1'b0,1'b0,6'd0,32'h7F800001,6'd1,32'hFFC00000,32'h7FFFFFFF,4'd7}, // R7
    '{32'h00000000,1'b1,1'b0,1'b1,6'd32,32'h0,6'd32,32'h0,32'h7FFFFFFF,4'd8},        // R8
    '{32'hFFFFFFFF,1'b1,1'b0,1'b0,6'd2,32'h7F800000,6'd3,32'hFF800000,32'h7F800000,4'd4}, // R4
    '{32'hFFFFFFFF,1'b0,1'b0,1'b0,6'd2,32'h7F800000,6'd3,32'hFF800000,32'hFF800000,4'd4}, // R4
    '{32'h80000000,1'b1,1'b1,1'b0,6'd32,32'h0,6'd32,32'h0,32'h4000001F,4'd3},        // R3
    '{32'h0000000C,1'b0,1'b1,1'b0,6'd2,32'h7F800000,6'd3,32'hFF800000,32'h7F800000,4'd5}, // R5
    '{32'h00000003,1'b1,1'b1,1'b1,6'd0,32'h80000000,6'd1,32'hFF800000,32'h7F800000,4'd5}  // R5
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [LANES*32-1:0] lane_words = '0;
  logic [LANES-1:0] lane_en = '0;
  logic pick_max = 1'b0, use_abs = 1'b0, nan_poison = 1'b0;
  logic res_valid;
  logic [31:0] res_word;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lane_minmax_reducer #(.LANES(LANES)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .lane_words(lane_words),
    .lane_en(lane_en), .pick_max(pick_max), .use_abs(use_abs),
    .nan_poison(nan_poison), .res_valid(res_valid), .res_word(res_word)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic drive(input row_t r);
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] w;
      w = (i % 2 == 0) ? 32'h40000000 + 32'(i) : 32'hC0000000 + 32'(i);
      if (r.i0 == 6'(i)) w = r.v0;
      if (r.i1 == 6'(i)) w = r.v1;
      lane_words[i*32+:32] = w;
    end
    lane_en    = r.mask;
    pick_max   = r.mx;
    use_abs    = r.ab;
    nan_poison = r.nn;
    op_valid   = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R9 reset valid", 32'(res_valid), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0, "R9 idle after reset", 32'(res_valid), 32'h0);

    for (int k = 0; k < NV + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT) begin
        row_t e;
        string tag;
        e = TBL[k-LAT];
        tag = $sformatf("R%0d row %0d", e.rq, k - LAT);
        check(res_valid == 1'b1, {tag, " valid"}, 32'(res_valid), 32'h1);
        check(res_word == e.exp, tag, res_word, e.exp);
      end
      if (k < NV) drive(TBL[k]);
      else op_valid = 1'b0;
    end

    repeat (3) @(negedge clk);
    drive(TBL[0]);
    @(negedge clk);
    op_valid = 1'b0;
    for (int c = 2; c <= LAT + 2; c++) begin
      @(negedge clk);
      check(res_valid == (c == LAT), "R9 single pulse latency", 32'(res_valid),
            32'(c == LAT));
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule